// File: doc/BRIEF.md
# Debug trigger state sequencer

This block steps an on-chip debug trigger through up to three intermediate states and then a final state, driven by match pulses from a set of comparator channels. When armed, the sequencer starts in state 1. On each match from an enabled channel it takes the step chosen by the control register of the state it is in. When it reaches the final state it raises a one-cycle trigger. That trigger is used to stop the core or to freeze trace capture.

The three per-state control registers and a match flag register share one bus address. A 2-bit bank select, supplied by a separate control register, picks which of the four is seen. The per-state registers hold a 4-bit next-state code. They cannot be changed while the sequencer is armed, so a sequence in progress always runs against a fixed program. The match flag register records which channel caused the final step. It can only be read.

Top module: `trig_seq`

## Requirements
- R1: After reset, state_o is 0 (idle), trig_o is 0, and every bank reads 0.
- R2: Bank select 00, 01 and 10 read the control registers of states 1, 2 and 3 in rdata_o[3:0], with rdata_o[7:4] always 0. Bank select 11 reads the match flag register: bit i is set for channel i.
- R3: A write with wr_i high stores wdata_i[3:0] into the selected state control register only when arm_i is low. With arm_i high the write is ignored. A write with bank select 11 is always ignored.
- R4: With arm_i high in idle, state_o becomes 1 on the next clock and the match flag register clears. With arm_i low, state_o returns to 0 on the next clock from any state.
- R5: In states 1, 2 and 3, an enabled match moves the sequencer on the next clock according to that state's code: 0000 goes to the final state (state_o = 4), 0001 to state 2, and 0010 to state 3.
- R6: A code other than 0000, 0001 or 0010 holds the sequencer in its current state on a match.
- R7: A match pulse counts only when the matching channel's cmp_en_i bit is set. A state with no enabled match holds.
- R8: When several enabled channels match in one cycle, at most one transition occurs. The lowest-numbered channel is the one recorded in the match flag register.
- R9: trig_o is high for exactly the one cycle in which state_o first shows 4. The final state then holds until arm_i falls. The match flag register keeps its value after disarm until the next arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the shared address |
| bank_sel_i | input | 2 | Bank select for the shared address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected bank |
| arm_i | input | 1 | Arms the sequencer while high |
| match_i | input | N_CH | Per-channel comparator match pulses |
| cmp_en_i | input | N_CH | Per-channel comparator enables |
| state_o | output | 3 | Current state: 0 idle, 1 to 3 intermediate, 4 final |
| trig_o | output | 1 | One-cycle pulse on reaching the final state |

## Verification
The final step and the priority choice between channels happen in the same cycle. Several enabled channels match at once while a disabled lower channel also fires. The sequencer must take a single step, and the flag must name the lowest enabled channel. A register write is also issued in the same cycle as arming and during the armed sequence, and readback must show it had no effect. A reference model in the bench predicts every cycle's state, trigger and readback. A scoreboard compares the model against the design one clock later.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int CODE_W = 4;
  localparam int N_STEP = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FINAL = 3'd4
  } seq_st_e;

  function automatic seq_st_e step_target(input logic [CODE_W-1:0] code, input seq_st_e cur);
    case (code)
      4'h0:    step_target = ST_FINAL;
      4'h1:    step_target = ST_TWO;
      4'h2:    step_target = ST_THREE;
      default: step_target = cur;
    endcase
  endfunction
endpackage

// File: rtl/trig_seq_regs.sv
module trig_seq_regs
  import trig_seq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int N_CH = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [1:0]               bank_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     arm_i,
  input  logic [N_CH-1:0]          flags_i,
  output logic [N_STEP*CODE_W-1:0] code_o,
  output logic [DW-1:0]            rdata_o
);
  logic [CODE_W-1:0] sc_q [N_STEP];

  for (genvar g = 0; g < N_STEP; g++) begin : g_step
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   sc_q[g] <= '0;
      else if (wr_i && !arm_i && bank_i == 2'(g))    sc_q[g] <= wdata_i[CODE_W-1:0];
    end
    assign code_o[g*CODE_W +: CODE_W] = sc_q[g];
  end

  always_comb begin
    rdata_o = '0;
    case (bank_i)
      2'd0:    rdata_o[CODE_W-1:0] = sc_q[0];
      2'd1:    rdata_o[CODE_W-1:0] = sc_q[1];
      2'd2:    rdata_o[CODE_W-1:0] = sc_q[2];
      default: rdata_o[N_CH-1:0]   = flags_i;
    endcase
  end
endmodule

// File: rtl/trig_seq_prio.sv
module trig_seq_prio #(
  parameter int N_CH = 4
) (
  input  logic [N_CH-1:0] req_i,
  output logic            hit_o,
  output logic [N_CH-1:0] gnt_o
);
  for (genvar i = 0; i < N_CH; i++) begin : g_gnt
    if (i == 0) begin : g_lsb
      assign gnt_o[i] = req_i[i];
    end else begin : g_up
      assign gnt_o[i] = req_i[i] & ~|req_i[i-1:0];
    end
  end
  assign hit_o = |req_i;
endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
  import trig_seq_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     arm_i,
  input  logic                     hit_i,
  input  logic [N_CH-1:0]          gnt_i,
  input  logic [N_STEP*CODE_W-1:0] code_i,
  output logic [2:0]               state_o,
  output logic                     trig_o,
  output logic [N_CH-1:0]          flags_o
);
  seq_st_e           st_q, st_d;
  logic              trig_q, trig_d;
  logic [N_CH-1:0]   flg_q, flg_d;
  logic [CODE_W-1:0] cur_code;

  always_comb begin
    cur_code = '0;
    case (st_q)
      ST_ONE:   cur_code = code_i[0        +: CODE_W];
      ST_TWO:   cur_code = code_i[CODE_W   +: CODE_W];
      ST_THREE: cur_code = code_i[2*CODE_W +: CODE_W];
      default:  cur_code = '0;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    trig_d = 1'b0;
    flg_d  = flg_q;
    if (!arm_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_d  = ST_ONE;
          flg_d = '0;
        end
        ST_ONE, ST_TWO, ST_THREE: begin
          if (hit_i) begin
            st_d = step_target(cur_code, st_q);
            if (st_d == ST_FINAL) begin
              trig_d = 1'b1;
              flg_d  = gnt_i;
            end
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      trig_q <= 1'b0;
      flg_q  <= '0;
    end else begin
      st_q   <= st_d;
      trig_q <= trig_d;
      flg_q  <= flg_d;
    end
  end

  assign state_o = st_q;
  assign trig_o  = trig_q;
  assign flags_o = flg_q;
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [1:0]      bank_sel_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            arm_i,
  input  logic [N_CH-1:0] match_i,
  input  logic [N_CH-1:0] cmp_en_i,
  output logic [2:0]      state_o,
  output logic            trig_o
);
  logic [N_STEP*CODE_W-1:0] sc_flat;
  logic [N_CH-1:0]          flags;
  logic [N_CH-1:0]          gnt;
  logic                     hit;

  trig_seq_regs #(.DW(DW), .N_CH(N_CH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .bank_i  (bank_sel_i),
    .wdata_i (wdata_i),
    .arm_i   (arm_i),
    .flags_i (flags),
    .code_o  (sc_flat),
    .rdata_o (rdata_o)
  );

  trig_seq_prio #(.N_CH(N_CH)) u_prio (
    .req_i (match_i & cmp_en_i),
    .hit_o (hit),
    .gnt_o (gnt)
  );

  trig_seq_fsm #(.N_CH(N_CH)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_i),
    .hit_i   (hit),
    .gnt_i   (gnt),
    .code_i  (sc_flat),
    .state_o (state_o),
    .trig_o  (trig_o),
    .flags_o (flags)
  );
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int DW   = 8,
  parameter int N_CH = 4,
  parameter int SCW  = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      bank_sel_i,
  input logic [DW-1:0]   rdata_o,
  input logic            arm_i,
  input logic [N_CH-1:0] match_i,
  input logic [N_CH-1:0] cmp_en_i,
  input logic [2:0]      state_o,
  input logic            trig_o,
  input logic [SCW-1:0]  sc_flat,
  input logic [N_CH-1:0] flags
);
  a_r9_trig_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (state_o == 3'd4 && $past(state_o) != 3'd4));

  a_r3_locked_when_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> $stable(sc_flat));

  a_r4_disarm_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> state_o == 3'd0);

  a_r4_arm_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && state_o == 3'd0) |=> state_o == 3'd1);

  a_r7_hold_no_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && state_o != 3'd0 && (match_i & cmp_en_i) == '0) |=> $stable(state_o));

  a_r8_single_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags));

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_sel_i != 2'd3 |-> rdata_o[DW-1:4] == '0);
endmodule

bind trig_seq trig_seq_chk #(.DW(DW), .N_CH(N_CH), .SCW(trig_seq_pkg::N_STEP*trig_seq_pkg::CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bank_sel_i (bank_sel_i),
  .rdata_o    (rdata_o),
  .arm_i      (arm_i),
  .match_i    (match_i),
  .cmp_en_i   (cmp_en_i),
  .state_o    (state_o),
  .trig_o     (trig_o),
  .sc_flat    (sc_flat),
  .flags      (flags)
);

// File: tb/sim_trig_seq.sv
`timescale 1ns/1ps
module sim_trig_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       arm = 1'b0;
  logic [3:0] match = 4'h0;
  logic [3:0] en = 4'h0;
  logic [2:0] state;
  logic       trig;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] st;
    logic       tr;
    logic [7:0] rd;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [3:0] msc [3];
  logic [2:0] ms;
  logic [3:0] mflg;

  always #5 clk = ~clk;

  trig_seq #(.DW(8), .N_CH(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .bank_sel_i(sel), .wdata_i(wdata),
    .rdata_o(rdata), .arm_i(arm), .match_i(match), .cmp_en_i(en),
    .state_o(state), .trig_o(trig)
  );

  // drive one cycle and push the model's prediction for after the next edge
  task automatic cyc(input logic w, input logic [1:0] s, input logic [7:0] d,
                     input logic a, input logic [3:0] m, input logic [3:0] e, input string tag);
    logic [2:0] nxt;
    logic       tr;
    logic [3:0] eff, code;
    exp_t it;
    @(negedge clk);
    wr = w; sel = s; wdata = d; arm = a; match = m; en = e;
    nxt = ms; tr = 1'b0; eff = m & e;
    if (!a) nxt = 3'd0;
    else if (ms == 3'd0) begin nxt = 3'd1; mflg = 4'h0; end
    else if (ms >= 3'd1 && ms <= 3'd3 && eff != 4'h0) begin
      code = msc[ms-1];
      case (code)
        4'h0: nxt = 3'd4;
        4'h1: nxt = 3'd2;
        4'h2: nxt = 3'd3;
        default: nxt = ms;
      endcase
      if (nxt == 3'd4) begin
        tr = 1'b1;
        mflg = eff & (~eff + 4'h1);
      end
    end
    if (w && !a && s != 2'd3) msc[s] = d[3:0];
    ms = nxt;
    it.st = nxt; it.tr = tr; it.tag = tag;
    it.rd = (s == 2'd3) ? {4'h0, mflg} : {4'h0, msc[s]};
    q.push_back(it);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        total++;
        if (state !== e.st || trig !== e.tr || rdata !== e.rd) begin
          bad++;
          $display("FAIL %s: st=%0d trig=%0b rd=%02h expected st=%0d trig=%0b rd=%02h",
                   e.tag, state, trig, rdata, e.st, e.tr, e.rd);
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 3; i++) msc[i] = 4'h0;
    ms = 3'd0; mflg = 4'h0;
    #12;
    // R1 during reset
    total++;
    if (state !== 3'd0 || trig !== 1'b0 || rdata !== 8'h00) begin
      bad++;
      $display("FAIL R1: st=%0d trig=%0b rd=%02h expected st=0 trig=0 rd=00", state, trig, rdata);
    end
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 2'd0, 8'h00, 0, 4'h0, 4'h0, "R1 bank0");
    cyc(0, 2'd1, 8'h00, 0, 4'h0, 4'h0, "R1 bank1");
    cyc(0, 2'd3, 8'h00, 0, 4'h0, 4'h0, "R1 bank3");
    // program: reserved bits dropped
    cyc(1, 2'd0, 8'hF1, 0, 4'h0, 4'h0, "R2 R3 bank0 write");
    cyc(1, 2'd1, 8'h32, 0, 4'h0, 4'h0, "R3 bank1 write");
    cyc(1, 2'd2, 8'hA0, 0, 4'h0, 4'h0, "R3 bank2 write");
    cyc(1, 2'd3, 8'hFF, 0, 4'h0, 4'h0, "R3 flag read-only");
    cyc(0, 2'd1, 8'h00, 0, 4'h0, 4'h0, "R2 bank1 read");
    // arm, with a write in the same cycle
    cyc(1, 2'd0, 8'h05, 1, 4'h0, 4'hF, "R4 R3 arm with write");
    cyc(1, 2'd2, 8'h07, 1, 4'h0, 4'hF, "R3 write while armed");
    cyc(0, 2'd2, 8'h00, 1, 4'h4, 4'h3, "R7 disabled match");
    cyc(0, 2'd0, 8'h00, 1, 4'h0, 4'hF, "R7 no match hold");
    cyc(0, 2'd0, 8'h00, 1, 4'hA, 4'hE, "R5 s1 to s2");
    cyc(0, 2'd1, 8'h00, 1, 4'h8, 4'hF, "R5 s2 to s3");
    cyc(0, 2'd3, 8'h00, 1, 4'hB, 4'hA, "R8 R9 s3 to final");
    cyc(0, 2'd3, 8'h00, 1, 4'hF, 4'hF, "R9 final holds");
    cyc(0, 2'd3, 8'h00, 0, 4'h0, 4'h0, "R4 R9 disarm");
    cyc(0, 2'd3, 8'h00, 0, 4'h0, 4'h0, "R9 flag kept");
    // undefined code holds
    cyc(1, 2'd0, 8'h05, 0, 4'h0, 4'h0, "R3 write code 5");
    cyc(0, 2'd3, 8'h00, 1, 4'h0, 4'h0, "R4 arm clears flags");
    cyc(0, 2'd0, 8'h00, 1, 4'hF, 4'hF, "R6 undefined code");
    cyc(0, 2'd0, 8'h00, 1, 4'h1, 4'h1, "R6 still held");
    cyc(0, 2'd0, 8'h00, 0, 4'h0, 4'h0, "R4 disarm from s1");
    // direct s1 to final
    cyc(1, 2'd0, 8'h00, 0, 4'h0, 4'h0, "R3 write code 0");
    cyc(0, 2'd0, 8'h00, 1, 4'h0, 4'h0, "R4 arm");
    cyc(0, 2'd3, 8'h00, 1, 4'hC, 4'hE, "R5 R8 s1 to final");
    cyc(0, 2'd3, 8'h00, 1, 4'h0, 4'h0, "R9 pulse ends");
    cyc(0, 2'd3, 8'h00, 0, 4'h0, 4'h0, "R4 disarm");
    // disarm mid-sequence from s2
    cyc(1, 2'd0, 8'h01, 0, 4'h0, 4'h0, "R3 write code 1");
    cyc(0, 2'd0, 8'h00, 1, 4'h0, 4'h0, "R4 arm");
    cyc(0, 2'd0, 8'h00, 1, 4'h1, 4'h1, "R5 s1 to s2");
    cyc(0, 2'd2, 8'h00, 0, 4'h1, 4'h1, "R4 disarm from s2");
    cyc(0, 2'd2, 8'h00, 0, 4'h0, 4'h0, "R2 bank2 read");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule